// File: doc/BRIEF.md
# Framebuffer Pixel Format Unpacker

This block sits between a framebuffer word fetcher and a display pipeline. It takes 32-bit words read from video memory and splits each one into the pixels it packs, handing out one pixel per clock. Source depths of 1, 2, 4 and 8 bits per pixel give palette indices. The 12, 16 and 32-bit depths give direct colour, which comes out as 8 bits for each of red, green and blue.

Both sides use a valid/ready handshake. The display mode is captured together with each accepted word, so a mode change takes effect on a word boundary. Several controls alter how a word is read. Byte swapping reads the word big-endian. Pixel reversal puts the first sub-byte pixel at the top of each byte. A red/blue swap exchanges the two outer channels. A 2-bit mux input picks how a 16-bit pixel is laid out. A line-start pulse drops whatever is left of the word being unpacked, so every display line begins on a word boundary.

Top module: `fb_pixel_unpack`

## Requirements
- R1: After reset, `pix_valid` is 0 and `in_ready` is 1.
- R2: The `cfg_depth` code gives the source depth: 0=1 bpp, 1=2 bpp, 2=4 bpp, 3=8 bpp, 4=16 bpp (format picked by `mux_sel`), 5=32 bpp, 6=16 bpp 5:6:5, 7=12 bpp held in a 16-bit container. A word yields exactly 32/bpp pixels, with 12 bpp counting as 16. All controls are sampled when the word is accepted, and later changes do not affect that word.
- R3: With no ordering control set, pixel k of a word is taken from bits [k*bpp +: bpp], so pixel 0 is the least significant field.
- R4: For codes 0 to 3, `pix_is_index` is 1, `pix_index` holds the field zero-extended to 8 bits, and `pix_rgb` is 0. For codes 4 to 7, `pix_is_index` is 0 and `pix_index` is 0.
- R5: When `cfg_byte_swap` is 1, the word's byte 0 and byte 3 trade places, and so do bytes 1 and 2, before any pixel is extracted. Pixel reversal is then ignored.
- R6: When `cfg_pix_rev` is 1 (and `cfg_byte_swap` is 0) at depths below 8 bpp, bytes are still taken lowest first, but inside each byte the first pixel is the most significant field. At 8 bpp and above the control has no effect.
- R7: `pix_rgb` is {R[23:16], G[15:8], B[7:0]}. A channel narrower than 8 bits is left-justified and its top bits are copied into the vacated low bits. At 32 bpp, R=bits[7:0], G=[15:8], B=[23:16], and bits [31:24] are ignored. At 12 bpp, R=[3:0], G=[7:4], B=[11:8].
- R8: 16-bit layouts: 5:5:5:1 is R=[4:0], G=[9:5], B=[14:10], with bit 15 ignored. 5:6:5 is R=[4:0], G=[10:5], B=[15:11]. For code 4, `mux_sel`=1 selects 5:5:5:1, `mux_sel`=0 or 2 selects 5:6:5, and `mux_sel`=3 selects 5:6:5 with red and blue always swapped. Code 6 is always 5:6:5.
- R9: When `cfg_bgr` is 1, red and blue are swapped on direct-colour output. The exception is `mux_sel`=3 at code 4, which swaps them regardless.
- R10: While `pix_valid` is 1 and `pix_ready` is 0, the output stays unchanged. A new word is accepted only when the last pixel of the held word is moving to the output. With `pix_ready` held at 1, back-to-back 32 bpp words give one pixel every cycle.
- R11: In a cycle where `line_start` is 1, `in_ready` is 0. The remaining pixels of the held word are discarded, and the next accepted word starts at its pixel 0.
- R12: A word accepted at clock edge N presents its pixel 0 after edge N+1, provided the output is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Fetched word is valid |
| in_data | input | 32 | Fetched framebuffer word |
| in_ready | output | 1 | Block can take a word this cycle |
| line_start | input | 1 | Pulse at the start of a display line |
| cfg_depth | input | 3 | Source depth code |
| cfg_byte_swap | input | 1 | Big-endian byte order in the word |
| cfg_pix_rev | input | 1 | Big-endian pixel order in each byte |
| cfg_bgr | input | 1 | Swap red and blue |
| mux_sel | input | 2 | 16-bit format selector |
| pix_valid | output | 1 | Output pixel is valid |
| pix_ready | input | 1 | Downstream takes the pixel |
| pix_is_index | output | 1 | Pixel is a palette index |
| pix_index | output | 8 | Palette index |
| pix_rgb | output | 24 | Direct colour, R in the top byte |

## Verification
The bench builds the block with its defaults: a 32-bit word and the 16-bit mux honoured. That setting brings all four `mux_sel` layouts within reach, along with every depth code. It does not reach the variant where code 4 is fixed at 5:5:5:1. The directed tests cover three timing cases: depth sampling at word acceptance, the one-pixel-per-cycle handover between words, and discarding part of a word on `line_start` while the output is stalled.

// File: rtl/fbu_pkg.sv
package fbu_pkg;

  typedef enum logic [2:0] {
    DEP_1B  = 3'd0,
    DEP_2B  = 3'd1,
    DEP_4B  = 3'd2,
    DEP_8B  = 3'd3,
    DEP_16B = 3'd4,
    DEP_32B = 3'd5,
    DEP_565 = 3'd6,
    DEP_12B = 3'd7
  } depth_e;

  typedef enum logic [2:0] {
    FMT_INDEX = 3'd0,
    FMT_5551  = 3'd1,
    FMT_565   = 3'd2,
    FMT_444   = 3'd3,
    FMT_888   = 3'd4
  } colfmt_e;

  typedef struct packed {
    depth_e  depth;
    colfmt_e fmt;
    logic    swap_rb;
    logic    rev_pix;
  } fbu_mode_t;

  // log2 of the container width in bits for each depth code
  function automatic logic [2:0] depth_log2(depth_e d);
    case (d)
      DEP_1B:  return 3'd0;
      DEP_2B:  return 3'd1;
      DEP_4B:  return 3'd2;
      DEP_8B:  return 3'd3;
      DEP_32B: return 3'd5;
      default: return 3'd4;
    endcase
  endfunction

  function automatic fbu_mode_t resolve_mode(depth_e d, logic bswap, logic prev,
                                             logic bgr, logic [1:0] mux, logic legacy);
    fbu_mode_t m;
    m.depth   = d;
    m.rev_pix = prev && !bswap && (d <= DEP_4B);
    m.swap_rb = bgr;
    case (d)
      DEP_16B: begin
        if (legacy) begin
          case (mux)
            2'd1:    m.fmt = FMT_5551;
            2'd3: begin
              m.fmt     = FMT_565;
              m.swap_rb = 1'b1;
            end
            default: m.fmt = FMT_565;
          endcase
        end else begin
          m.fmt = FMT_5551;
        end
      end
      DEP_32B: m.fmt = FMT_888;
      DEP_565: m.fmt = FMT_565;
      DEP_12B: m.fmt = FMT_444;
      default: m.fmt = FMT_INDEX;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/fbu_word_stage.sv
module fbu_word_stage
  import fbu_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter bit LEGACY_MUX = 1'b1,
  localparam int POS_W     = $clog2(WORD_W),
  localparam int NBYTES    = WORD_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  input  logic              line_start,
  input  logic [2:0]        cfg_depth,
  input  logic              cfg_byte_swap,
  input  logic              cfg_pix_rev,
  input  logic              cfg_bgr,
  input  logic [1:0]        mux_sel,
  input  logic              take,
  output logic [WORD_W-1:0] word_q,
  output fbu_mode_t         mode_q,
  output logic [POS_W-1:0]  pos_q,
  output logic              full_q
);

  logic [WORD_W-1:0] swapped;
  logic [POS_W:0]    ppw;
  logic              last;
  logic              accept;

  for (genvar b = 0; b < NBYTES; b++) begin : g_bswap
    assign swapped[8*b +: 8] = cfg_byte_swap ? in_data[8*(NBYTES-1-b) +: 8]
                                             : in_data[8*b +: 8];
  end

  assign ppw      = (POS_W+1)'(WORD_W) >> depth_log2(mode_q.depth);
  assign last     = ({1'b0, pos_q} == (ppw - 1'b1));
  assign in_ready = !line_start && (!full_q || (take && last));
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      pos_q  <= '0;
      word_q <= '0;
      mode_q <= '0;
    end else if (line_start) begin
      full_q <= 1'b0;
      pos_q  <= '0;
    end else begin
      if (take && full_q) begin
        pos_q <= last ? '0 : pos_q + 1'b1;
        if (last) full_q <= 1'b0;
      end
      if (accept) begin
        word_q <= swapped;
        mode_q <= resolve_mode(depth_e'(cfg_depth), cfg_byte_swap, cfg_pix_rev,
                               cfg_bgr, mux_sel, LEGACY_MUX);
        full_q <= 1'b1;
        pos_q  <= '0;
      end
    end
  end

  // R11: a line start never lets a word in
  a_r11_no_accept_on_line: assert property (@(posedge clk) disable iff (rst)
    line_start |-> !in_ready);

  // R2: the pixel position stays inside the word's pixel count
  a_r2_pos_in_word: assert property (@(posedge clk) disable iff (rst)
    full_q |-> ({1'b0, pos_q} < ppw));

endmodule

// File: rtl/fbu_pixel_extract.sv
module fbu_pixel_extract
  import fbu_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int POS_W = $clog2(WORD_W)
) (
  input  logic [WORD_W-1:0] word,
  input  fbu_mode_t         mode,
  input  logic [POS_W-1:0]  pos,
  output logic [23:0]       field
);

  logic [2:0]        lg;
  logic [6:0]        bpp;
  logic [POS_W-1:0]  off_base;
  logic [POS_W-1:0]  rev_mask;
  logic [POS_W-1:0]  off;
  logic [WORD_W-1:0] mask;

  assign lg       = depth_log2(mode.depth);
  assign bpp      = 7'd1 << lg;
  assign off_base = pos << lg;
  assign rev_mask = POS_W'(7'd8 - bpp);
  assign off      = mode.rev_pix ? (off_base ^ rev_mask) : off_base;
  assign mask     = WORD_W'((64'd1 << bpp) - 64'd1);
  assign field    = 24'((word >> off) & mask);

endmodule

// File: rtl/fbu_color_expand.sv
module fbu_color_expand
  import fbu_pkg::*;
(
  input  logic [23:0] field,
  input  fbu_mode_t   mode,
  output logic        is_index,
  output logic [7:0]  index,
  output logic [23:0] rgb
);

  function automatic logic [7:0] rep5(logic [4:0] x);
    return {x, x[4:2]};
  endfunction

  function automatic logic [7:0] rep6(logic [5:0] x);
    return {x, x[5:4]};
  endfunction

  function automatic logic [7:0] rep4(logic [3:0] x);
    return {x, x};
  endfunction

  logic [7:0] r, g, b;

  always_comb begin
    r = 8'd0;
    g = 8'd0;
    b = 8'd0;
    case (mode.fmt)
      FMT_5551: begin
        r = rep5(field[4:0]);
        g = rep5(field[9:5]);
        b = rep5(field[14:10]);
      end
      FMT_565: begin
        r = rep5(field[4:0]);
        g = rep6(field[10:5]);
        b = rep5(field[15:11]);
      end
      FMT_444: begin
        r = rep4(field[3:0]);
        g = rep4(field[7:4]);
        b = rep4(field[11:8]);
      end
      FMT_888: begin
        r = field[7:0];
        g = field[15:8];
        b = field[23:16];
      end
      default: ;
    endcase
  end

  always_comb begin
    is_index = (mode.fmt == FMT_INDEX);
    index    = is_index ? field[7:0] : 8'd0;
    if (is_index)          rgb = 24'd0;
    else if (mode.swap_rb) rgb = {b, g, r};
    else                   rgb = {r, g, b};
  end

endmodule

// File: rtl/fb_pixel_unpack.sv
module fb_pixel_unpack
  import fbu_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter bit LEGACY_MUX = 1'b1,
  localparam int POS_W     = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  input  logic              line_start,
  input  logic [2:0]        cfg_depth,
  input  logic              cfg_byte_swap,
  input  logic              cfg_pix_rev,
  input  logic              cfg_bgr,
  input  logic [1:0]        mux_sel,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic              pix_is_index,
  output logic [7:0]        pix_index,
  output logic [23:0]       pix_rgb
);

  logic [WORD_W-1:0] word_q;
  fbu_mode_t         mode_q;
  logic [POS_W-1:0]  pos_q;
  logic              full_q;
  logic              adv;
  logic [23:0]       field;
  logic              nx_is_index;
  logic [7:0]        nx_index;
  logic [23:0]       nx_rgb;

  logic              pix_valid_q;
  logic              pix_is_index_q;
  logic [7:0]        pix_index_q;
  logic [23:0]       pix_rgb_q;
  fbu_mode_t         out_mode_q;

  assign adv = !pix_valid_q || pix_ready;

  fbu_word_stage #(.WORD_W(WORD_W), .LEGACY_MUX(LEGACY_MUX)) u_word (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_data       (in_data),
    .in_ready      (in_ready),
    .line_start    (line_start),
    .cfg_depth     (cfg_depth),
    .cfg_byte_swap (cfg_byte_swap),
    .cfg_pix_rev   (cfg_pix_rev),
    .cfg_bgr       (cfg_bgr),
    .mux_sel       (mux_sel),
    .take          (adv),
    .word_q        (word_q),
    .mode_q        (mode_q),
    .pos_q         (pos_q),
    .full_q        (full_q)
  );

  fbu_pixel_extract #(.WORD_W(WORD_W)) u_extract (
    .word  (word_q),
    .mode  (mode_q),
    .pos   (pos_q),
    .field (field)
  );

  fbu_color_expand u_expand (
    .field    (field),
    .mode     (mode_q),
    .is_index (nx_is_index),
    .index    (nx_index),
    .rgb      (nx_rgb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_valid_q    <= 1'b0;
      pix_is_index_q <= 1'b0;
      pix_index_q    <= '0;
      pix_rgb_q      <= '0;
      out_mode_q     <= '0;
    end else if (adv) begin
      pix_valid_q <= full_q && !line_start;
      if (full_q && !line_start) begin
        pix_is_index_q <= nx_is_index;
        pix_index_q    <= nx_index;
        pix_rgb_q      <= nx_rgb;
        out_mode_q     <= mode_q;
      end
    end
  end

  assign pix_valid    = pix_valid_q;
  assign pix_is_index = pix_is_index_q;
  assign pix_index    = pix_index_q;
  assign pix_rgb      = pix_rgb_q;

  // R10: a stalled pixel does not move
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (rst)
    pix_valid_q && !pix_ready |=> pix_valid_q && $stable(pix_rgb_q)
      && $stable(pix_index_q) && $stable(pix_is_index_q));

  // R4: a 1 bpp index never exceeds one bit
  a_r4_index_width: assert property (@(posedge clk) disable iff (rst)
    pix_valid_q && (out_mode_q.depth == DEP_1B) |-> (pix_index_q[7:1] == 7'd0));

  // R7: 5:6:5 channels carry their top bits in the low bits
  a_r7_replicate565: assert property (@(posedge clk) disable iff (rst)
    pix_valid_q && (out_mode_q.fmt == FMT_565) |->
      (pix_rgb_q[18:16] == pix_rgb_q[23:21]) && (pix_rgb_q[2:0] == pix_rgb_q[7:5])
      && (pix_rgb_q[9:8] == pix_rgb_q[15:14]));

endmodule

// File: tb/fb_pixel_unpack_test.sv
module fb_pixel_unpack_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready;
  logic        line_start = 1'b0;
  logic [2:0]  cfg_depth = '0;
  logic        cfg_byte_swap = 1'b0;
  logic        cfg_pix_rev = 1'b0;
  logic        cfg_bgr = 1'b0;
  logic [1:0]  mux_sel = '0;
  logic        pix_valid;
  logic        pix_ready = 1'b1;
  logic        pix_is_index;
  logic [7:0]  pix_index;
  logic [23:0] pix_rgb;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fb_pixel_unpack uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .line_start(line_start), .cfg_depth(cfg_depth), .cfg_byte_swap(cfg_byte_swap),
    .cfg_pix_rev(cfg_pix_rev), .cfg_bgr(cfg_bgr), .mux_sel(mux_sel),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_is_index(pix_is_index),
    .pix_index(pix_index), .pix_rgb(pix_rgb)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int e5(int x); return (x << 3) | (x >> 2); endfunction
  function automatic int e6(int x); return (x << 2) | (x >> 4); endfunction

  function automatic int ppw(int d);
    if (d <= 5) return 32 >> d;
    return 2;
  endfunction

  // expected {is_index, index, rgb} of pixel k, built from the requirements
  function automatic logic [32:0] exp_pix(logic [31:0] w, int d, bit bs, bit pr,
                                          bit bgr, int mx, int k);
    logic [31:0] ww, h;
    int bpp, off, v, r, g, b, t;
    bit sw;
    ww = bs ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
    if (d <= 3) begin
      bpp = 1 << d;
      off = k * bpp;
      if (pr && !bs && d < 3) off = (off / 8) * 8 + (8 - bpp - (off % 8));
      v = int'((ww >> off) & ((32'd1 << bpp) - 32'd1));
      return {1'b1, 8'(v), 24'd0};
    end
    sw = bgr;
    if (d == 5) begin
      r = int'(ww[7:0]); g = int'(ww[15:8]); b = int'(ww[23:16]);
    end else begin
      h = (ww >> (16 * k)) & 32'hffff;
      if (d == 7) begin
        r = int'(h[3:0]) * 17; g = int'(h[7:4]) * 17; b = int'(h[11:8]) * 17;
      end else if (d == 4 && mx == 1) begin
        r = e5(int'(h[4:0])); g = e5(int'(h[9:5])); b = e5(int'(h[14:10]));
      end else begin
        if (d == 4 && mx == 3) sw = 1'b1;
        r = e5(int'(h[4:0])); g = e6(int'(h[10:5])); b = e5(int'(h[15:11]));
      end
    end
    if (sw) begin t = r; r = b; b = t; end
    return {1'b0, 8'd0, 8'(r), 8'(g), 8'(b)};
  endfunction

  function automatic logic [32:0] act_pix();
    return {pix_is_index, pix_index, pix_rgb};
  endfunction

  task automatic set_cfg(int d, bit bs, bit pr, bit bgr, int mx);
    cfg_depth = 3'(d); cfg_byte_swap = bs; cfg_pix_rev = pr; cfg_bgr = bgr; mux_sel = 2'(mx);
  endtask

  // one word, full pixel sequence, with mode scrambled after acceptance (R2)
  task automatic run_word(input logic [31:0] w, input int d, input bit bs, input bit pr,
                          input bit bgr, input int mx, input string req);
    logic [32:0] e;
    @(negedge clk);
    set_cfg(d, bs, pr, bgr, mx);
    pix_ready = 1'b1;
    in_data = w;
    in_valid = 1'b1;
    chk(in_ready === 1'b1, "R10", "ready with idle stage", 64'(in_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    set_cfg((d + 3) % 8, !bs, !pr, !bgr, 3 - mx);
    chk(pix_valid === 1'b0, "R12", "no pixel one edge after accept", 64'(pix_valid), 64'd0);
    for (int k = 0; k < ppw(d); k++) begin
      @(negedge clk);
      e = exp_pix(w, d, bs, pr, bgr, mx, k);
      chk(pix_valid === 1'b1, "R2", $sformatf("%s valid pixel %0d", req, k), 64'(pix_valid), 64'd1);
      chk(act_pix() === e, req, $sformatf("pixel %0d of depth %0d", k, d), 64'(act_pix()), 64'(e));
    end
    @(negedge clk);
    chk(pix_valid === 1'b0, "R2", $sformatf("no extra pixel depth %0d", d), 64'(pix_valid), 64'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(pix_valid === 1'b0, "R1", "pix_valid after reset", 64'(pix_valid), 64'd0);
    chk(in_ready === 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'd1);
  endtask

  task automatic t_depths();
    run_word(32'hA5C3_0F96, 0, 0, 0, 0, 0, "R3");
    run_word(32'h1B2D_E4C6, 1, 0, 0, 0, 0, "R3");
    run_word(32'h8765_4321, 2, 0, 0, 0, 0, "R4");
    run_word(32'hF00D_C0DE, 3, 0, 0, 0, 0, "R4");
    run_word(32'h1357_9BDF, 3, 0, 1, 0, 0, "R6");
  endtask

  task automatic t_ordering();
    run_word(32'h0F5A_C396, 0, 0, 1, 0, 0, "R6");
    run_word(32'h1B2D_E4C6, 1, 0, 1, 0, 0, "R6");
    run_word(32'h8765_4321, 2, 1, 0, 0, 0, "R5");
    run_word(32'hA5C3_0F96, 0, 1, 1, 0, 0, "R5");
    run_word(32'h1234_ABCD, 4, 1, 0, 0, 2, "R5");
  endtask

  task automatic t_direct();
    run_word(32'hFF12_3456, 5, 0, 0, 0, 0, "R7");
    run_word(32'h7712_3456, 5, 0, 0, 1, 0, "R9");
    run_word(32'hF9A5_0C3B, 7, 0, 0, 0, 0, "R7");
    run_word(32'h8421_F0A5, 6, 0, 0, 0, 0, "R8");
    run_word(32'h8421_F0A5, 6, 0, 0, 1, 0, "R9");
  endtask

  task automatic t_mux();
    run_word(32'hFC1F_83E0, 4, 0, 0, 0, 1, "R8");
    run_word(32'h7C1F_83E0, 4, 0, 0, 0, 1, "R8");
    run_word(32'hB5A7_4C2E, 4, 0, 0, 0, 0, "R8");
    run_word(32'hB5A7_4C2E, 4, 0, 0, 1, 2, "R8");
    run_word(32'hB5A7_4C2E, 4, 0, 0, 0, 3, "R8");
    run_word(32'hB5A7_4C2E, 4, 0, 0, 1, 3, "R9");
  endtask

  task automatic t_stream();
    logic [31:0] ws [3];
    ws[0] = 32'h0011_2233; ws[1] = 32'h0044_5566; ws[2] = 32'h0077_8899;
    @(negedge clk);
    set_cfg(5, 0, 0, 0, 0);
    pix_ready = 1'b1;
    fork
      begin
        for (int i = 0; i < 3; i++) begin
          in_data = ws[i];
          in_valid = 1'b1;
          while (!in_ready) @(negedge clk);
          @(posedge clk);
          @(negedge clk);
        end
        in_valid = 1'b0;
      end
      begin
        int guard = 0;
        @(negedge clk);
        while (!pix_valid && guard < 10) begin @(negedge clk); guard++; end
        for (int i = 0; i < 3; i++) begin
          chk(pix_valid === 1'b1, "R10", $sformatf("stream pixel %0d each cycle", i), 64'(pix_valid), 64'd1);
          chk(act_pix() === exp_pix(ws[i], 5, 0, 0, 0, 0, 0), "R10", $sformatf("stream value %0d", i),
              64'(act_pix()), 64'(exp_pix(ws[i], 5, 0, 0, 0, 0, 0)));
          @(negedge clk);
        end
      end
    join
  endtask

  task automatic t_backpressure();
    logic [31:0] a, b, c;
    a = 32'h00AA_0001; b = 32'h00BB_0002; c = 32'h00CC_0003;
    @(negedge clk);
    set_cfg(5, 0, 0, 0, 0);
    pix_ready = 1'b0;
    in_data = a; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_data = b;
    chk(in_ready === 1'b1, "R10", "second word accepted while output empty", 64'(in_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    in_data = c;
    chk(in_ready === 1'b0, "R10", "word refused while stage and output full", 64'(in_ready), 64'd0);
    chk(act_pix() === exp_pix(a, 5, 0, 0, 0, 0, 0), "R10", "first word at output",
        64'(act_pix()), 64'(exp_pix(a, 5, 0, 0, 0, 0, 0)));
    repeat (2) @(negedge clk);
    chk(pix_valid === 1'b1 && act_pix() === exp_pix(a, 5, 0, 0, 0, 0, 0), "R10", "held under stall",
        64'(act_pix()), 64'(exp_pix(a, 5, 0, 0, 0, 0, 0)));
    chk(in_ready === 1'b0, "R10", "still refusing under stall", 64'(in_ready), 64'd0);
    pix_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(act_pix() === exp_pix(b, 5, 0, 0, 0, 0, 0), "R10", "second word after release",
        64'(act_pix()), 64'(exp_pix(b, 5, 0, 0, 0, 0, 0)));
    @(negedge clk);
    chk(act_pix() === exp_pix(c, 5, 0, 0, 0, 0, 0), "R10", "third word after release",
        64'(act_pix()), 64'(exp_pix(c, 5, 0, 0, 0, 0, 0)));
    @(negedge clk);
    chk(pix_valid === 1'b0, "R10", "drained", 64'(pix_valid), 64'd0);
  endtask

  task automatic t_line_start();
    logic [31:0] w1, w2;
    w1 = 32'h4433_2211; w2 = 32'hDDCC_BBAA;
    @(negedge clk);
    set_cfg(3, 0, 0, 0, 0);
    pix_ready = 1'b0;
    in_data = w1; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    line_start = 1'b1;
    in_data = w2; in_valid = 1'b1;
    chk(in_ready === 1'b0, "R11", "in_ready low during line start", 64'(in_ready), 64'd0);
    @(negedge clk);
    line_start = 1'b0;
    chk(pix_valid === 1'b1 && pix_index === 8'h11, "R11", "held pixel survives line start",
        64'(pix_index), 64'h11);
    pix_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(pix_valid === 1'b0, "R11", "rest of old word discarded", 64'(pix_valid), 64'd0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(pix_valid === 1'b1 && pix_index === w2[8*k +: 8], "R11", $sformatf("new line pixel %0d", k),
          64'(pix_index), 64'(w2[8*k +: 8]));
    end
    @(negedge clk);
    chk(pix_valid === 1'b0, "R11", "no pixel after new word", 64'(pix_valid), 64'd0);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_depths();
    t_ordering();
    t_direct();
    t_mux();
    t_stream();
    t_backpressure();
    t_line_start();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule